// File: doc/BRIEF.md
# Two-Colour Hardware Cursor Overlay

This block sits in the pixel pipeline and draws a 64 by 64 pointer on top of the pixel stream. It holds the cursor image in a local 1024-byte RAM that is written directly. Every image line takes 16 bytes and carries two 64-bit bit planes. The 2-bit code formed from the two planes at a pixel selects one of four results: the incoming pixel unchanged, the incoming pixel inverted, colour 0 or colour 1. Colour 0 and colour 1 are each kept as three separate 8-bit component registers.

The host writes the cursor position as screen coordinate plus 64 on each axis. A cursor can therefore hang partly off the left or top edge while every stored value stays unsigned. A written position is only a pending value. It moves into the active copy at a frame boundary that falls outside vertical retrace, so the cursor never jumps in the middle of a frame. The control register turns the overlay on or off. Each composited pixel appears one clock after it enters, together with its valid flag.

Top module: `cursor_overlay`

## Requirements
- R1: After reset, outValid and all three output components are 0, the cursor is disabled and the active position is X=0, Y=0.
- R2: The output for a pixel presented with pixValid=1 appears exactly one clock later with outValid=1. A cycle with pixValid=0 gives outValid=0 one clock later.
- R3: When the control field (register address 0, bits 1:0) holds any value other than 3, every pixel passes through unchanged. Value 3 enables the cursor. Control writes take effect on the next clock.
- R4: With active position (X, Y), a pixel at beam (bx, by) lies inside the cursor when bx+64−X is in [0, 63] and by+64−Y is in [0, 63]. That difference is the cursor column and the cursor line. Pixels outside the cursor pass through unchanged.
- R5: Image byte address 16·L+k (k=0..7) holds the high plane bits for columns 8k..8k+7 of line L. Byte 16·L+8+k holds the low plane bits for the same columns. In each byte, bit 7 belongs to the leftmost column.
- R6: The code {high, low} selects the result: 00 gives the input pixel, 01 gives its bitwise inverse, 10 gives colour 0 and 11 gives colour 1.
- R7: Register map: address 1 is the position (Y in data bits 27:16, X in bits 11:0). Addresses 2, 3 and 4 are colour 0 red, green and blue. Addresses 5, 6 and 7 are colour 1 red, green and blue, each in data bits 7:0. A colour write affects pixels presented in later cycles. A pixel presented in the same cycle as the write uses the old value.
- R8: A position write updates only the pending position. The pending value is copied to the active position on a clock where frameStart=1 and vRetrace=0. A frameStart during vRetrace leaves the active position unchanged. A pixel presented in the same cycle as the copy still uses the old position.
- R9: A stored position below 64 clips the cursor at the screen edge. For example, with X=10 the pixel at bx=0 shows cursor column 54, and bx=9 shows column 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 4 | Register address |
| regData | input | 32 | Register write data |
| imgWe | input | 1 | Image RAM write strobe |
| imgAddr | input | 10 | Image RAM byte address |
| imgData | input | 8 | Image RAM write byte |
| frameStart | input | 1 | Frame boundary pulse |
| vRetrace | input | 1 | Vertical retrace in progress |
| pixValid | input | 1 | Input pixel is active |
| beamX | input | 12 | Screen column of the input pixel |
| beamY | input | 12 | Screen line of the input pixel |
| inRed | input | 8 | Underlying red |
| inGreen | input | 8 | Underlying green |
| inBlue | input | 8 | Underlying blue |
| outValid | output | 1 | Output pixel is active |
| outRed | output | 8 | Composited red |
| outGreen | output | 8 | Composited green |
| outBlue | output | 8 | Composited blue |

## Verification
Two functions can fall on the same clock: a register update and the compositing of a pixel. The register update is either a colour write or the frame-boundary copy of the pending position. The bench provokes both cases.

In the first case, a colour 0 red write is issued in the same cycle as a pixel whose code selects colour 0. The output for that pixel must carry the old colour, and the same pixel repeated one cycle later must carry the new colour.

In the second case, frameStart is raised with vRetrace low while a pixel is presented that lies outside the old window but inside the new one. That pixel must pass through unchanged, and the same pixel on the next clock must show the new window's code.

// File: rtl/cursor_pkg.sv
package cursor_pkg;

  localparam int DATA_W          = 32;
  localparam int NUM_COLOUR_REGS = 6;
  localparam int POS_Y_LSB       = 16;

  localparam logic [3:0] REG_CTRL     = 4'd0;
  localparam logic [3:0] REG_POS      = 4'd1;
  localparam logic [3:0] REG_COL_BASE = 4'd2;

  localparam logic [1:0] CTRL_ON = 2'b11;

  typedef enum logic [1:0] {
    CODE_PASS = 2'b00,
    CODE_INV  = 2'b01,
    CODE_C0   = 2'b10,
    CODE_C1   = 2'b11
  } pixCode_e;

  typedef struct packed {
    logic                       wrCtrl;
    logic                       wrPos;
    logic [NUM_COLOUR_REGS-1:0] wrColour;
    logic                       latchPos;
    logic                       wrImg;
  } curStrobe_t;

endpackage

// File: rtl/cursor_ctrl.sv
module cursor_ctrl
  import cursor_pkg::*;
(
  input  logic       regWe,
  input  logic [3:0] regAddr,
  input  logic       imgWe,
  input  logic       frameStart,
  input  logic       vRetrace,
  output curStrobe_t stb
);

  logic [NUM_COLOUR_REGS-1:0] colHit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COLOUR_REGS; gi++) begin : g_colDec
      assign colHit[gi] = regWe && (regAddr == REG_COL_BASE + 4'(gi));
    end
  endgenerate

  always_comb begin
    stb          = '0;
    stb.wrCtrl   = regWe && (regAddr == REG_CTRL);
    stb.wrPos    = regWe && (regAddr == REG_POS);
    stb.wrColour = colHit;
    stb.latchPos = frameStart && !vRetrace;
    stb.wrImg    = imgWe;
  end

endmodule

// File: rtl/cursor_image_ram.sv
module cursor_image_ram #(
  parameter int AW = 10,
  parameter int DW = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wAddr,
  input  logic [DW-1:0] wData,
  input  logic [AW-1:0] rAddrA,
  input  logic [AW-1:0] rAddrB,
  output logic [DW-1:0] rDataA,
  output logic [DW-1:0] rDataB
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  assign rDataA = mem[rAddrA];
  assign rDataB = mem[rAddrB];

endmodule

// File: rtl/cursor_datapath.sv
module cursor_datapath
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int COMP_W  = 8,
  parameter int CUR_DIM = 64,
  localparam int IDX_W  = $clog2(CUR_DIM),
  localparam int IMG_AW = 2 * IDX_W - 2,
  localparam int DIFF_W = COORD_W + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  curStrobe_t           stb,
  input  logic [DATA_W-1:0]    regData,
  input  logic [IMG_AW-1:0]    imgAddr,
  input  logic [7:0]           imgData,
  input  logic                 pixValid,
  input  logic [COORD_W-1:0]   beamX,
  input  logic [COORD_W-1:0]   beamY,
  input  logic [3*COMP_W-1:0]  inRgb,
  output logic                 outValid,
  output logic [3*COMP_W-1:0]  outRgb,
  output logic                 curEnabled,
  output logic [2*COORD_W-1:0] actPos
);

  logic [1:0]         ctrlReg;
  logic [COORD_W-1:0] pendX, pendY, actX, actY;
  logic [NUM_COLOUR_REGS*COMP_W-1:0] colFlat;

  logic unusedPosBits;
  assign unusedPosBits = ^{regData[DATA_W-1:POS_Y_LSB+COORD_W],
                           regData[POS_Y_LSB-1:COORD_W]};

  // control and position registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      pendX   <= '0;
      pendY   <= '0;
      actX    <= '0;
      actY    <= '0;
    end else begin
      if (stb.wrCtrl) ctrlReg <= regData[1:0];
      if (stb.wrPos) begin
        pendX <= regData[COORD_W-1:0];
        pendY <= regData[POS_Y_LSB +: COORD_W];
      end
      if (stb.latchPos) begin
        actX <= pendX;
        actY <= pendY;
      end
    end
  end

  // colour component registers
  genvar gi;
  generate
    for (gi = 0; gi < NUM_COLOUR_REGS; gi++) begin : g_colReg
      logic [COMP_W-1:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 q <= '0;
        else if (stb.wrColour[gi]) q <= regData[COMP_W-1:0];
      end
      assign colFlat[gi*COMP_W +: COMP_W] = q;
    end
  endgenerate

  assign curEnabled = (ctrlReg == CTRL_ON);
  assign actPos     = {actY, actX};

  // window test with the +CUR_DIM bias folded in
  logic [DIFF_W-1:0] dX, dY;
  logic              inX, inY, hit;
  assign dX  = DIFF_W'(beamX) + DIFF_W'(CUR_DIM) - DIFF_W'(actX);
  assign dY  = DIFF_W'(beamY) + DIFF_W'(CUR_DIM) - DIFF_W'(actY);
  assign inX = dX < DIFF_W'(CUR_DIM);
  assign inY = dY < DIFF_W'(CUR_DIM);
  assign hit = curEnabled && inX && inY;

  logic [IDX_W-1:0]  col, line;
  logic [IMG_AW-1:0] hiAddr, loAddr;
  logic [7:0]        hiByte, loByte;
  assign col    = dX[IDX_W-1:0];
  assign line   = dY[IDX_W-1:0];
  assign hiAddr = {line, 1'b0, col[IDX_W-1:3]};
  assign loAddr = {line, 1'b1, col[IDX_W-1:3]};

  cursor_image_ram #(.AW(IMG_AW), .DW(8)) u_ram (
    .clk    (clk),
    .we     (stb.wrImg),
    .wAddr  (imgAddr),
    .wData  (imgData),
    .rAddrA (hiAddr),
    .rAddrB (loAddr),
    .rDataA (hiByte),
    .rDataB (loByte)
  );

  pixCode_e code;
  assign code = pixCode_e'({hiByte[~col[2:0]], loByte[~col[2:0]]});

  logic [3*COMP_W-1:0] mixRgb;
  always_comb begin
    mixRgb = inRgb;
    if (hit) begin
      unique case (code)
        CODE_PASS: mixRgb = inRgb;
        CODE_INV:  mixRgb = ~inRgb;
        CODE_C0:   mixRgb = {colFlat[0*COMP_W +: COMP_W], colFlat[1*COMP_W +: COMP_W],
                             colFlat[2*COMP_W +: COMP_W]};
        CODE_C1:   mixRgb = {colFlat[3*COMP_W +: COMP_W], colFlat[4*COMP_W +: COMP_W],
                             colFlat[5*COMP_W +: COMP_W]};
        default:   mixRgb = inRgb;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outRgb   <= '0;
    end else begin
      outValid <= pixValid;
      outRgb   <= mixRgb;
    end
  end

endmodule

// File: rtl/cursor_overlay.sv
module cursor_overlay
  import cursor_pkg::*;
#(
  parameter int COORD_W = 12,
  parameter int COMP_W  = 8,
  parameter int CUR_DIM = 64,
  localparam int IMG_AW = 2 * $clog2(CUR_DIM) - 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [3:0]         regAddr,
  input  logic [DATA_W-1:0]  regData,
  input  logic               imgWe,
  input  logic [IMG_AW-1:0]  imgAddr,
  input  logic [7:0]         imgData,
  input  logic               frameStart,
  input  logic               vRetrace,
  input  logic               pixValid,
  input  logic [COORD_W-1:0] beamX,
  input  logic [COORD_W-1:0] beamY,
  input  logic [COMP_W-1:0]  inRed,
  input  logic [COMP_W-1:0]  inGreen,
  input  logic [COMP_W-1:0]  inBlue,
  output logic               outValid,
  output logic [COMP_W-1:0]  outRed,
  output logic [COMP_W-1:0]  outGreen,
  output logic [COMP_W-1:0]  outBlue
);

  curStrobe_t           stb;
  logic                 curEnabled;
  logic [2*COORD_W-1:0] actPos;
  logic [3*COMP_W-1:0]  outRgb;

  cursor_ctrl u_ctrl (
    .regWe      (regWe),
    .regAddr    (regAddr),
    .imgWe      (imgWe),
    .frameStart (frameStart),
    .vRetrace   (vRetrace),
    .stb        (stb)
  );

  cursor_datapath #(.COORD_W(COORD_W), .COMP_W(COMP_W), .CUR_DIM(CUR_DIM)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regData    (regData),
    .imgAddr    (imgAddr),
    .imgData    (imgData),
    .pixValid   (pixValid),
    .beamX      (beamX),
    .beamY      (beamY),
    .inRgb      ({inRed, inGreen, inBlue}),
    .outValid   (outValid),
    .outRgb     (outRgb),
    .curEnabled (curEnabled),
    .actPos     (actPos)
  );

  assign {outRed, outGreen, outBlue} = outRgb;

endmodule

// File: rtl/cursor_overlay_checker.sv
module cursor_overlay_checker #(
  parameter int COORD_W = 12,
  parameter int COMP_W  = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic               pixValid,
  input logic               outValid,
  input logic [COMP_W-1:0]  inRed,
  input logic [COMP_W-1:0]  outRed,
  input logic               curEnabled,
  input logic               frameStart,
  input logic               vRetrace,
  input logic [2*COORD_W-1:0] actPos,
  input logic [5:0]         wrColour
);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid);

  a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid);

  a_r3_pass_when_off: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !curEnabled) |=> (outRed == $past(inRed)));

  a_r8_pos_held: assert property (@(posedge clk) disable iff (!rstN)
    !(frameStart && !vRetrace) |=> $stable(actPos));

  always_comb begin
    if (rstN) begin
      a_r7_one_colour_reg: assert ($onehot0(wrColour));
    end
  end

endmodule

bind cursor_overlay cursor_overlay_checker #(.COORD_W(COORD_W), .COMP_W(COMP_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .pixValid   (pixValid),
  .outValid   (outValid),
  .inRed      (inRed),
  .outRed     (outRed),
  .curEnabled (curEnabled),
  .frameStart (frameStart),
  .vRetrace   (vRetrace),
  .actPos     (actPos),
  .wrColour   (stb.wrColour)
);

// File: tb/cursor_overlay_bench.sv
module cursor_overlay_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regData = '0;
  logic        imgWe = 1'b0;
  logic [9:0]  imgAddr = '0;
  logic [7:0]  imgData = '0;
  logic        frameStart = 1'b0;
  logic        vRetrace = 1'b0;
  logic        pixValid = 1'b0;
  logic [11:0] beamX = '0;
  logic [11:0] beamY = '0;
  logic [7:0]  inRed = '0, inGreen = '0, inBlue = '0;
  logic        outValid;
  logic [7:0]  outRed, outGreen, outBlue;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [23:0] col0 = 24'h112233;
  logic [23:0] col1 = 24'hAABBCC;

  always #2 clk = ~clk;

  cursor_overlay u_cursor_overlay (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr), .regData(regData),
    .imgWe(imgWe), .imgAddr(imgAddr), .imgData(imgData),
    .frameStart(frameStart), .vRetrace(vRetrace), .pixValid(pixValid),
    .beamX(beamX), .beamY(beamY), .inRed(inRed), .inGreen(inGreen), .inBlue(inBlue),
    .outValid(outValid), .outRed(outRed), .outGreen(outGreen), .outBlue(outBlue)
  );

  // stimulus: beamX, beamY, input RGB, expected code (0..3 per R6, 4 = outside)
  localparam logic [50:0] VEC [12] = '{
    {12'd100, 12'd50,  24'h102030, 3'd0},
    {12'd101, 12'd50,  24'h0F00F0, 3'd1},
    {12'd102, 12'd50,  24'h445566, 3'd2},
    {12'd103, 12'd50,  24'h778899, 3'd3},
    {12'd163, 12'd50,  24'h010203, 3'd3},
    {12'd164, 12'd50,  24'h0A0B0C, 3'd4},
    {12'd99,  12'd50,  24'h0D0E0F, 3'd4},
    {12'd100, 12'd113, 24'h123456, 3'd3},
    {12'd100, 12'd114, 24'h654321, 3'd4},
    {12'd100, 12'd49,  24'hABCDEF, 3'd4},
    {12'd120, 12'd60,  24'h5A5A5A, 3'd2},
    {12'd133, 12'd77,  24'hC3C3C3, 3'd0}
  };

  function automatic logic [23:0] expRgb(input int code, input logic [23:0] inp);
    case (code)
      1: return ~inp;
      2: return col0;
      3: return col1;
      default: return inp;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wreg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic frame(input logic retr);
    @(negedge clk);
    frameStart = 1'b1; vRetrace = retr;
    @(negedge clk);
    frameStart = 1'b0; vRetrace = 1'b0;
  endtask

  task automatic pix(input int x, input int y, input logic [23:0] rgb, output logic [23:0] res);
    @(negedge clk);
    pixValid = 1'b1; beamX = 12'(x); beamY = 12'(y);
    {inRed, inGreen, inBlue} = rgb;
    @(negedge clk);
    res = {outRed, outGreen, outBlue};
    pixValid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [23:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 outValid", 32'(outValid), 0);
    check("R1 rgb", 32'({outRed, outGreen, outBlue}), 0);
    rstN = 1'b1;
    pix(0, 0, 24'h13579B, r);
    check("R1 disabled pass", 32'(r), 32'h13579B);
    check("R2 outValid high", 32'(outValid), 1);
    @(negedge clk);
    check("R2 outValid low", 32'(outValid), 0);

    // load image: code(line, col) = (line + col) & 3, per R5 layout
    for (int l = 0; l < 64; l++) begin
      for (int k = 0; k < 16; k++) begin
        logic [7:0] b;
        for (int bi = 0; bi < 8; bi++) begin
          int c;
          int cd;
          c = 8 * (k % 8) + (7 - bi);
          cd = (c + l) & 3;
          b[bi] = (k < 8) ? cd[1] : cd[0];
        end
        @(negedge clk);
        imgWe = 1'b1; imgAddr = 10'(16 * l + k); imgData = b;
      end
    end
    @(negedge clk);
    imgWe = 1'b0;

    // R7 registers
    wreg(4'd2, 32'h11); wreg(4'd3, 32'h22); wreg(4'd4, 32'h33);
    wreg(4'd5, 32'hAA); wreg(4'd6, 32'hBB); wreg(4'd7, 32'hCC);
    wreg(4'd1, (32'd114 << 16) | 32'd164);
    frame(1'b0);

    // R3 disabled until control = 3
    pix(103, 50, 24'h778899, r);
    check("R3 ctrl0 pass", 32'(r), 32'h778899);
    wreg(4'd0, 32'h2);
    pix(103, 50, 24'h778899, r);
    check("R3 ctrl2 pass", 32'(r), 32'h778899);
    wreg(4'd0, 32'h3);

    // table walk: R4 window, R5 layout, R6 codes
    for (int i = 0; i < 12; i++) begin
      logic [50:0] v;
      v = VEC[i];
      pix(int'(v[50:39]), int'(v[38:27]), v[26:3], r);
      check($sformatf("R4/R5/R6 vec%0d", i), 32'(r), 32'(expRgb(int'(v[2:0]), v[26:3])));
    end

    // R8: frameStart during retrace does not apply the pending position
    wreg(4'd1, (32'd10 << 16) | 32'd10);
    frame(1'b1);
    pix(101, 50, 24'h0F00F0, r);
    check("R8 held in retrace", 32'(r), 32'hF0FF0F);
    frame(1'b0);
    pix(101, 50, 24'h0F00F0, r);
    check("R8 applied after retrace", 32'(r), 32'h0F00F0);

    // R9 clipping with position (10,10)
    pix(1, 0, 24'h00FF00, r);
    check("R9 col55", 32'(r), 32'hFF00FF);
    pix(9, 0, 24'h00FF00, r);
    check("R9 col63", 32'(r), 32'hFF00FF);
    pix(10, 0, 24'h00FF00, r);
    check("R9 past right edge", 32'(r), 32'h00FF00);
    pix(0, 9, 24'h00FF00, r);
    check("R9 line63", 32'(r), 32'hFF00FF);

    // R7 same-cycle colour write and pixel
    @(negedge clk);
    pixValid = 1'b1; beamX = 12'd2; beamY = 12'd0; {inRed, inGreen, inBlue} = 24'h777777;
    regWe = 1'b1; regAddr = 4'd2; regData = 32'h55;
    @(negedge clk);
    regWe = 1'b0;
    check("R7 same-cycle old colour", 32'({outRed, outGreen, outBlue}), 32'h112233);
    @(negedge clk);
    check("R7 new colour", 32'({outRed, outGreen, outBlue}), 32'h552233);
    pixValid = 1'b0;
    col0 = 24'h552233;

    // R8 same-cycle position copy and pixel
    wreg(4'd1, (32'd114 << 16) | 32'd164);
    @(negedge clk);
    pixValid = 1'b1; beamX = 12'd101; beamY = 12'd50; {inRed, inGreen, inBlue} = 24'h0F00F0;
    frameStart = 1'b1; vRetrace = 1'b0;
    @(negedge clk);
    frameStart = 1'b0;
    check("R8 same-cycle old position", 32'({outRed, outGreen, outBlue}), 32'h0F00F0);
    @(negedge clk);
    check("R8 new position", 32'({outRed, outGreen, outBlue}), 32'hF0FF0F);
    pixValid = 1'b0;
    @(negedge clk);
    check("R2 idle after stream", 32'(outValid), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule